// File: doc/BRIEF.md
# Merged Event Interrupt Combiner

This block gathers three Ethernet-side events into one summary interrupt line. The events are a change of the link-good level in either direction, a pulse from a statistics counter that has wrapped, and a transmit failure. A transmit failure is seen when the transmit-enable flag drops while the transmit-success flag stays low. Each event has its own enable bit in a control register. An event that happens while its enable is set is latched as pending, and the summary line is high while any source is pending.

There is no common status clear. Each source is cleared by a side effect of its own. A link event is cleared by a control-register write that puts its enable to 0. A rollover is cleared by a read of the counter register, or by a control write that disables it. A transmit failure is cleared by a transmit-configuration write that sets transmit enable back to 1, or by a control write that disables it. The register bus decode sits outside the block. It hands over write strobes with the written bit values and a strobe for counter reads.

Top module: `merged_irq`

## Requirements
- R1: After reset all three enable bits are 0, no source is pending, and `summaryIrq` is 0.
- R2: With the link enable set, a change of `linkOkAsync` in either direction passes through a `SYNC_STAGES`-flop synchronizer and an edge compare. `summaryIrq` rises at the (`SYNC_STAGES`+1)-th rising clock edge after the change.
- R3: A control write with `ctrlLinkEnIn`=0 clears a pending link event. It also clears the link enable.
- R4: With the rollover enable set, a `rollPulse` sampled high at a clock edge makes `summaryIrq` high from that edge on.
- R5: A pending rollover is cleared by `cntReadStrobe` or by a control write with `ctrlRollEnIn`=0.
- R6: A transmit failure is flagged when `txEnable` is 1 at one clock edge and 0 at the next while `txSuccess` is 0. If `txSuccess` is 1 at that edge, no failure is flagged.
- R7: A pending transmit failure is cleared by a config write with `cfgTxEnIn`=1, or by a control write with `ctrlTxErrEnIn`=0. A config write with `cfgTxEnIn`=0 leaves it pending.
- R8: An event that occurs while its enable bit is 0 is not latched, and `summaryIrq` stays 0 for it.
- R9: `summaryIrq` is the OR of the three pending flags. A pending flag holds until its own acknowledge.
- R10: If a source's new event and its acknowledge fall in the same cycle, the event wins and the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| linkOkAsync | input | 1 | Link-good level, asynchronous to clk |
| rollPulse | input | 1 | One-cycle counter wrap pulse |
| txEnable | input | 1 | Current transmit-enable flag |
| txSuccess | input | 1 | Transmit-success flag |
| cntReadStrobe | input | 1 | Counter register read strobe |
| ctrlWrite | input | 1 | Control register write strobe |
| ctrlLinkEnIn | input | 1 | Written value of the link enable |
| ctrlRollEnIn | input | 1 | Written value of the rollover enable |
| ctrlTxErrEnIn | input | 1 | Written value of the transmit-failure enable |
| cfgWrite | input | 1 | Transmit-config register write strobe |
| cfgTxEnIn | input | 1 | Written value of transmit enable |
| summaryIrq | output | 1 | Merged interrupt |

## Verification
The bench builds the block with the default `SYNC_STAGES` of 2. That fixes the link latency at three edges, so a directed test can show the link source still quiet two edges after a toggle and high on the third. Random cycles mix link toggles, rollover pulses, transmit flag changes and every acknowledge path, so the same cycle often holds both an event and its acknowledge. This exercises the rule that the event wins.

// File: rtl/merged_irq_pkg.sv
package merged_irq_pkg;
  localparam int NUM_SRC = 3;
  localparam int SRC_LINK = 0;
  localparam int SRC_ROLL = 1;
  localparam int SRC_TX   = 2;

  typedef struct packed {
    logic [NUM_SRC-1:0] arm;  // current enable per source
    logic [NUM_SRC-1:0] ack;  // acknowledge strobe per source
  } irqCtl_t;
endpackage

// File: rtl/mirq_ctrl.sv
module mirq_ctrl
  import merged_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cntReadStrobe,
  input  logic    ctrlWrite,
  input  logic    ctrlLinkEnIn,
  input  logic    ctrlRollEnIn,
  input  logic    ctrlTxErrEnIn,
  input  logic    cfgWrite,
  input  logic    cfgTxEnIn,
  output irqCtl_t ctl
);
  logic [NUM_SRC-1:0] enQ;
  logic [NUM_SRC-1:0] wrVal;
  logic [NUM_SRC-1:0] disableStb;

  always_comb begin
    wrVal = '0;
    wrVal[SRC_LINK] = ctrlLinkEnIn;
    wrVal[SRC_ROLL] = ctrlRollEnIn;
    wrVal[SRC_TX]   = ctrlTxErrEnIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enQ <= '0;
    else if (ctrlWrite) enQ <= wrVal;
  end

  assign disableStb = {NUM_SRC{ctrlWrite}} & ~wrVal;

  always_comb begin
    ctl.arm = enQ;
    ctl.ack = disableStb;
    ctl.ack[SRC_ROLL] = disableStb[SRC_ROLL] | cntReadStrobe;
    ctl.ack[SRC_TX]   = disableStb[SRC_TX] | (cfgWrite & cfgTxEnIn);
  end
endmodule

// File: rtl/mirq_datapath.sv
module mirq_datapath
  import merged_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               linkOkAsync,
  input  logic               rollPulse,
  input  logic               txEnable,
  input  logic               txSuccess,
  input  irqCtl_t            ctl,
  output logic [NUM_SRC-1:0] pendVec,
  output logic               linkEdge,
  output logic               summaryIrq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   linkPrevQ;
  logic                   txPrevQ;
  logic [NUM_SRC-1:0]     evtVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '0;
      linkPrevQ <= 1'b0;
    end else begin
      syncQ     <= {syncQ[LAST-1:0], linkOkAsync};
      linkPrevQ <= syncQ[LAST];
    end
  end

  // previous transmit-enable level, tracked in and out of reset
  always_ff @(posedge clk) txPrevQ <= txEnable;

  assign linkEdge = syncQ[LAST] ^ linkPrevQ;

  always_comb begin
    evtVec = '0;
    evtVec[SRC_LINK] = linkEdge;
    evtVec[SRC_ROLL] = rollPulse;
    evtVec[SRC_TX]   = txPrevQ & ~txEnable & ~txSuccess;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    logic setStb;
    assign setStb = evtVec[i] & ctl.arm[i];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           pendVec[i] <= 1'b0;
      else if (setStb)     pendVec[i] <= 1'b1;
      else if (ctl.ack[i]) pendVec[i] <= 1'b0;
    end
  end

  assign summaryIrq = |pendVec;
endmodule

// File: rtl/merged_irq.sv
module merged_irq
  import merged_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic clk,
  input  logic rstN,
  input  logic linkOkAsync,
  input  logic rollPulse,
  input  logic txEnable,
  input  logic txSuccess,
  input  logic cntReadStrobe,
  input  logic ctrlWrite,
  input  logic ctrlLinkEnIn,
  input  logic ctrlRollEnIn,
  input  logic ctrlTxErrEnIn,
  input  logic cfgWrite,
  input  logic cfgTxEnIn,
  output logic summaryIrq
);
  irqCtl_t            ctl;
  logic [NUM_SRC-1:0] pendVec;
  logic [NUM_SRC-1:0] armVec;
  logic               linkEdge;

  mirq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cntReadStrobe(cntReadStrobe),
    .ctrlWrite(ctrlWrite), .ctrlLinkEnIn(ctrlLinkEnIn),
    .ctrlRollEnIn(ctrlRollEnIn), .ctrlTxErrEnIn(ctrlTxErrEnIn),
    .cfgWrite(cfgWrite), .cfgTxEnIn(cfgTxEnIn), .ctl(ctl)
  );

  mirq_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .linkOkAsync(linkOkAsync),
    .rollPulse(rollPulse), .txEnable(txEnable), .txSuccess(txSuccess),
    .ctl(ctl), .pendVec(pendVec), .linkEdge(linkEdge),
    .summaryIrq(summaryIrq)
  );

  assign armVec = ctl.arm;
endmodule

// File: rtl/merged_irq_chk.sv
module merged_irq_chk
  import merged_irq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               rollPulse,
  input logic               txEnable,
  input logic               txSuccess,
  input logic               cntReadStrobe,
  input logic               ctrlWrite,
  input logic               ctrlLinkEnIn,
  input logic               cfgWrite,
  input logic               cfgTxEnIn,
  input logic [NUM_SRC-1:0] armVec,
  input logic [NUM_SRC-1:0] pendVec,
  input logic               linkEdge,
  input logic               summaryIrq
);
  a_r4_roll_latch: assert property (@(posedge clk) disable iff (!rstN)
    rollPulse && armVec[SRC_ROLL] |=> pendVec[SRC_ROLL]);

  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    rollPulse && armVec[SRC_ROLL] && cntReadStrobe |=> summaryIrq);

  a_r5_read_ack: assert property (@(posedge clk) disable iff (!rstN)
    cntReadStrobe && !rollPulse |=> !pendVec[SRC_ROLL]);

  a_r8_roll_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !armVec[SRC_ROLL] && !pendVec[SRC_ROLL] |=> !pendVec[SRC_ROLL]);

  a_r3_link_ack: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrite && !ctrlLinkEnIn && !linkEdge |=> !pendVec[SRC_LINK]);

  a_r6_tx_fail: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEnable) && !txSuccess && armVec[SRC_TX] |=> pendVec[SRC_TX]);

  a_r7_tx_ack: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite && cfgTxEnIn && !($fell(txEnable) && !txSuccess)
    |=> !pendVec[SRC_TX]);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    summaryIrq && !cntReadStrobe && !ctrlWrite && !cfgWrite |=> summaryIrq);
endmodule

bind merged_irq merged_irq_chk chk (
  .clk(clk), .rstN(rstN), .rollPulse(rollPulse), .txEnable(txEnable),
  .txSuccess(txSuccess), .cntReadStrobe(cntReadStrobe),
  .ctrlWrite(ctrlWrite), .ctrlLinkEnIn(ctrlLinkEnIn),
  .cfgWrite(cfgWrite), .cfgTxEnIn(cfgTxEnIn), .armVec(armVec),
  .pendVec(pendVec), .linkEdge(linkEdge), .summaryIrq(summaryIrq)
);

// File: tb/merged_irq_test.sv
`timescale 1ns/1ps
module merged_irq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic linkOkAsync = 0, rollPulse = 0, txEnable = 0, txSuccess = 0;
  logic cntReadStrobe = 0, ctrlWrite = 0, ctrlLinkEnIn = 0, ctrlRollEnIn = 0;
  logic ctrlTxErrEnIn = 0, cfgWrite = 0, cfgTxEnIn = 0;
  logic summaryIrq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic mS1 = 0, mS2 = 0, mPrev = 0, mTxPrev = 0;
  logic [2:0] mEn = '0, mPend = '0;

  always #2.5 clk = ~clk;

  merged_irq uut (.*);

  function automatic logic [2:0] nextPend(logic [2:0] pend, logic [2:0] en,
                                          logic [2:0] evt, logic [2:0] ack);
    logic [2:0] r;
    for (int i = 0; i < 3; i++)
      r[i] = (evt[i] && en[i]) ? 1'b1 : (ack[i] ? 1'b0 : pend[i]);
    return r;
  endfunction

  task automatic modelStep();
    logic [2:0] evt, ack, wv;
    wv  = {ctrlTxErrEnIn, ctrlRollEnIn, ctrlLinkEnIn};
    evt = {mTxPrev && !txEnable && !txSuccess, rollPulse, mS2 != mPrev};
    ack = {ctrlWrite && !wv[2] || cfgWrite && cfgTxEnIn,
           ctrlWrite && !wv[1] || cntReadStrobe,
           ctrlWrite && !wv[0]};
    mPend = nextPend(mPend, mEn, evt, ack);
    if (ctrlWrite) mEn = wv;
    mPrev = mS2; mS2 = mS1; mS1 = linkOkAsync;
    mTxPrev = txEnable;
  endtask

  task automatic cycle();
    @(posedge clk);
    if (rstN) modelStep();
    else mTxPrev = txEnable;
    @(negedge clk);
  endtask

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: summaryIrq=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clearStrobes();
    rollPulse = 0; cntReadStrobe = 0; ctrlWrite = 0; cfgWrite = 0;
  endtask

  task automatic writeCtrl(logic l, logic r, logic t);
    ctrlWrite = 1; ctrlLinkEnIn = l; ctrlRollEnIn = r; ctrlTxErrEnIn = t;
    cycle(); clearStrobes();
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    cycle(); cycle();
    check("R1 in reset", summaryIrq, 1'b0);
    rstN = 1;
    cycle();
    check("R1 after reset", summaryIrq, 1'b0);

    // R8: events with all enables 0
    rollPulse = 1; cycle(); clearStrobes();
    linkOkAsync = 1; txEnable = 1; cycle(); txEnable = 0; cycle();
    cycle(); cycle();
    check("R8 disabled events", summaryIrq, 1'b0);

    // R4 / R9 / R5 rollover
    writeCtrl(0, 1, 0);
    rollPulse = 1; cycle(); clearStrobes();
    check("R4 rollover latched", summaryIrq, 1'b1);
    cycle(); cycle();
    check("R9 held until ack", summaryIrq, 1'b1);
    cntReadStrobe = 1; cycle(); clearStrobes();
    check("R5 counter read ack", summaryIrq, 1'b0);
    // R10 event and ack together
    rollPulse = 1; cntReadStrobe = 1; cycle(); clearStrobes();
    check("R10 event wins", summaryIrq, 1'b1);
    writeCtrl(0, 0, 0);
    check("R5 disable ack", summaryIrq, 1'b0);

    // R2 / R3 link latency
    writeCtrl(1, 0, 0);
    linkOkAsync = 0; cycle(); cycle();
    check("R2 edge two", summaryIrq, 1'b0);
    cycle();
    check("R2 edge three", summaryIrq, 1'b1);
    writeCtrl(1, 0, 0);
    check("R3 write keeping enable", summaryIrq, 1'b1);
    writeCtrl(0, 0, 0);
    check("R3 disable ack", summaryIrq, 1'b0);

    // R6 / R7 transmit failure
    writeCtrl(0, 0, 1);
    txEnable = 1; cycle(); txSuccess = 1; txEnable = 0; cycle();
    check("R6 success fall ignored", summaryIrq, 1'b0);
    txSuccess = 0; txEnable = 1; cycle(); txEnable = 0; cycle();
    check("R6 failure latched", summaryIrq, 1'b1);
    cfgWrite = 1; cfgTxEnIn = 0; cycle(); clearStrobes();
    check("R7 cfg write of 0 ignored", summaryIrq, 1'b1);
    cfgWrite = 1; cfgTxEnIn = 1; txEnable = 1; cycle(); clearStrobes();
    check("R7 cfg re-enable ack", summaryIrq, 1'b0);
    txEnable = 0; cycle();
    check("R6 second failure", summaryIrq, 1'b1);
    writeCtrl(0, 0, 0);
    check("R7 disable ack", summaryIrq, 1'b0);
    check("R9 model agrees", summaryIrq, |mPend);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      linkOkAsync   = ($urandom % 8) == 0 ? ~linkOkAsync : linkOkAsync;
      rollPulse     = ($urandom % 6) == 0;
      txEnable      = ($urandom % 4) == 0 ? ~txEnable : txEnable;
      txSuccess     = ($urandom % 2) == 0;
      cntReadStrobe = ($urandom % 7) == 0;
      ctrlWrite     = ($urandom % 9) == 0;
      ctrlLinkEnIn  = ($urandom % 3) != 0;
      ctrlRollEnIn  = ($urandom % 3) != 0;
      ctrlTxErrEnIn = ($urandom % 3) != 0;
      cfgWrite      = ($urandom % 10) == 0;
      cfgTxEnIn     = ($urandom % 2) == 0;
      cycle();
      check("R9 random vs model", summaryIrq, |mPend);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule